// File: doc/BRIEF.md
# Segmented Scrambling Element Encoder for a Two-Bank Current DAC

This block turns a signed DAC code into per-element drive lines for two identical banks of return-to-zero current elements. Each bank holds 26 elements: sixteen coarse elements of weight 32 and five pairs of fine elements of weights 1, 2, 4, 8 and 16. Every element has an up source and a down source. When it is driven, it adds plus or minus half its weight, so the signed sum over a bank can reach every integer step from -287 to +287 LSB.

A bank-select input picks which bank carries the pulse in the current reference period. The other bank stays completely off. Outside the pulse window every line returns to zero.

Element choice is scrambled from one period to the next so that mismatch between elements turns into noise instead of distortion. The positive coarse elements form a thermometer run that starts at a pseudo-random place on a ring of sixteen. Within a fine pair whose digit is zero, a pseudo-random bit decides which member goes up. The scrambling state advances once at the end of every window. It is therefore constant for the whole of one window.

Top module: `seg_dem_enc`

## Requirements
- R1: While reset is asserted, and until the first cycle after a sampled window, all four output vectors are zero.
- R2: If `win` is low at a rising clock edge, all 104 output lines are zero after that edge (return to zero).
- R3: If `win` is high at an edge, then after that edge only the bank picked by `bank_sel` has any line active: `bank_sel`=1 picks the hi bank and `bank_sel`=0 picks the lo bank. The other bank's up and down lines are all zero.
- R4: In the driven bank, every one of the 26 elements has exactly one of its up or down lines asserted.
- R5: The bit layout of each vector is fixed. Bits 0..15 are coarse elements of weight 32. Bits 16+2j and 17+2j form the pair of weight 2^j, for j=0..4. The driven bank's sum, taking +w for each up element and -w for each down element, equals twice the two's-complement `code` sampled at the same edge, for codes in -287..287. The result appears one cycle after the sample.
- R6: Codes above 287 are driven as 287, and codes below -287 are driven as -287.
- R7: A fine pair whose digit is zero drives one member up and one member down. Which member goes up is chosen pseudo-randomly per period, so both orientations occur for every pair over many periods.
- R8: The up coarse elements form one contiguous run on the ring of sixteen (at most two up/down transitions around the ring). The start of the run varies between periods.
- R9: During one window, while `code` and `bank_sel` are unchanged, the drive pattern stays identical from cycle to cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| code | input | 10 | Signed two's-complement DAC code |
| bank_sel | input | 1 | Selects the bank for this period: 1 = hi, 0 = lo |
| win | input | 1 | Pulse window; elements may be active only after edges where it is high |
| hi_up | output | 26 | Up-source enables, hi bank |
| hi_dn | output | 26 | Down-source enables, hi bank |
| lo_up | output | 26 | Up-source enables, lo bank |
| lo_dn | output | 26 | Down-source enables, lo bank |

## Verification
Every output is a register, so the drive pattern produced from `code`, `bank_sel` and `win` at one rising edge becomes visible right after that edge and is due exactly one cycle after the sample. The bench changes inputs on the falling edge. At each falling edge, before applying new values, it compares the outputs against the inputs it applied one half-cycle before the last rising edge. Holding behaviour is judged between consecutive cycles of the same window. Scrambling variety is judged only at the end, over thousands of windows.

// File: rtl/seg_dem_enc.sv
module seg_dem_enc #(
  parameter int CODE_W  = 10,
  parameter int NCOARSE = 16,
  parameter int NPAIR   = 5
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [CODE_W-1:0]           code,
  input  logic                        bank_sel,
  input  logic                        win,
  output logic [NCOARSE+2*NPAIR-1:0]  hi_up,
  output logic [NCOARSE+2*NPAIR-1:0]  hi_dn,
  output logic [NCOARSE+2*NPAIR-1:0]  lo_up,
  output logic [NCOARSE+2*NPAIR-1:0]  lo_dn
);
  localparam int NEL  = NCOARSE + 2*NPAIR;
  localparam int RB   = $clog2(NCOARSE);
  localparam int KW   = RB + 1;
  localparam int CWT  = 1 << NPAIR;
  localparam int OFS  = NCOARSE * CWT / 2;
  localparam int MAXV = OFS + CWT - 1;
  localparam int LW   = 16;

  logic [LW-1:0]    lfsr;
  logic             win_q;
  logic [RB-1:0]    rot;
  logic [NPAIR-1:0] rnd;
  logic [NEL-1:0]   up_n;
  logic             neg;
  logic [NPAIR-1:0] mag;
  logic [KW-1:0]    k_l;

  assign rot = lfsr[RB-1:0];
  assign rnd = lfsr[RB+NPAIR-1:RB];

  always_comb begin
    int v, u, kk, r;
    v = int'($signed(code));
    if (v > MAXV) v = MAXV;
    else if (v < -MAXV) v = -MAXV;
    u  = v + OFS;
    kk = (u + CWT/2) >>> NPAIR;
    if (kk < 0) kk = 0;
    else if (kk > NCOARSE) kk = NCOARSE;
    r   = u - kk * CWT;
    neg = (r < 0);
    mag = NPAIR'(neg ? -r : r);
    k_l = KW'(kk);
  end

  for (genvar i = 0; i < NCOARSE; i++) begin : g_coarse
    logic [RB-1:0] idx;
    assign idx     = RB'(i) - rot;
    assign up_n[i] = {1'b0, idx} < k_l;
  end

  for (genvar j = 0; j < NPAIR; j++) begin : g_pair
    assign up_n[NCOARSE+2*j]   = mag[j] ? ~neg : rnd[j];
    assign up_n[NCOARSE+2*j+1] = mag[j] ? ~neg : ~rnd[j];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lfsr  <= 16'hACE1;
      win_q <= 1'b0;
      hi_up <= '0;
      hi_dn <= '0;
      lo_up <= '0;
      lo_dn <= '0;
    end else begin
      win_q <= win;
      if (win_q && !win)
        lfsr <= {lfsr[LW-2:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      hi_up <= (win &&  bank_sel) ?  up_n : '0;
      hi_dn <= (win &&  bank_sel) ? ~up_n : '0;
      lo_up <= (win && !bank_sel) ?  up_n : '0;
      lo_dn <= (win && !bank_sel) ? ~up_n : '0;
    end
  end
endmodule

// File: rtl/seg_dem_enc_chk.sv
module seg_dem_enc_chk #(
  parameter int CODE_W  = 10,
  parameter int NCOARSE = 16,
  parameter int NPAIR   = 5
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic [CODE_W-1:0]           code,
  input logic                        bank_sel,
  input logic                        win,
  input logic [NCOARSE+2*NPAIR-1:0]  hi_up,
  input logic [NCOARSE+2*NPAIR-1:0]  hi_dn,
  input logic [NCOARSE+2*NPAIR-1:0]  lo_up,
  input logic [NCOARSE+2*NPAIR-1:0]  lo_dn
);
  localparam int NEL  = NCOARSE + 2*NPAIR;
  localparam int CWT  = 1 << NPAIR;
  localparam int MAXV = NCOARSE * CWT / 2 + CWT - 1;

  function automatic int wsum(input logic [NEL-1:0] u);
    int s = 0;
    for (int i = 0; i < NEL; i++) begin
      int w = (i < NCOARSE) ? CWT : (1 << ((i - NCOARSE) / 2));
      s += u[i] ? w : -w;
    end
    return s;
  endfunction

  function automatic int satc(input logic [CODE_W-1:0] c);
    int v = int'($signed(c));
    if (v > MAXV) v = MAXV;
    if (v < -MAXV) v = -MAXV;
    return v;
  endfunction

  p_rz_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !win |=> ((hi_up | hi_dn | lo_up | lo_dn) == '0));

  p_bank_hi_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (win && bank_sel) |=> ((lo_up | lo_dn) == '0));

  p_bank_lo_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (win && !bank_sel) |=> ((hi_up | hi_dn) == '0));

  p_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((hi_up & hi_dn) == '0) && ((lo_up & lo_dn) == '0));

  p_drive_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (win && bank_sel) |=> (&(hi_up ^ hi_dn)));

  p_sum_hi_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (win && bank_sel) |=> (wsum(hi_up) == 2 * satc($past(code))));

  p_sum_lo_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (win && !bank_sel) |=> (wsum(lo_up) == 2 * satc($past(code))));

  p_sat_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (win && bank_sel && (int'($signed(code)) > MAXV)) |=> (wsum(hi_up) == 2 * MAXV));

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(win) && win && $stable(code) && $stable(bank_sel))
      |=> ($stable(hi_up) && $stable(lo_up)));
endmodule

bind seg_dem_enc seg_dem_enc_chk #(.CODE_W(CODE_W), .NCOARSE(NCOARSE), .NPAIR(NPAIR)) u_chk (.*);

// File: tb/test_seg_dem_enc.sv
`timescale 1ns/1ps
module test_seg_dem_enc;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        win = 1'b0;
  logic        bank_sel = 1'b0;
  logic [9:0]  code = '0;
  logic [25:0] hi_up, hi_dn, lo_up, lo_dn;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  logic        pw = 0, ps = 0;
  logic [9:0]  pc = '0;
  logic        qw = 0, qs = 0;
  logic [9:0]  qc = '0;
  logic [25:0] q_du = '0;
  bit          seen_start [16];
  bit          seen_or [5][2];

  seg_dem_enc i_seg_dem_enc (
    .clk(clk), .rst_n(rst_n), .code(code), .bank_sel(bank_sel), .win(win),
    .hi_up(hi_up), .hi_dn(hi_dn), .lo_up(lo_up), .lo_dn(lo_dn));

  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int satv(input logic [9:0] c);
    int v = int'($signed(c));
    if (v > 287) v = 287;
    if (v < -287) v = -287;
    return v;
  endfunction

  function automatic int wsum(input logic [25:0] u);
    int s = 0;
    for (int i = 0; i < 26; i++) begin
      int w = (i < 16) ? 32 : (1 << ((i - 16) / 2));
      s += u[i] ? w : -w;
    end
    return s;
  endfunction

  task automatic check_out();
    logic [25:0] du, dd, iu, id;
    int e, v, tr, cp;
    du = '0;
    if (!pw) begin
      chk((hi_up | hi_dn | lo_up | lo_dn) == '0, "R2", "lines active outside window",
          $countones(hi_up | hi_dn | lo_up | lo_dn), 0);
    end else begin
      du = ps ? hi_up : lo_up;
      dd = ps ? hi_dn : lo_dn;
      iu = ps ? lo_up : hi_up;
      id = ps ? lo_dn : hi_dn;
      chk((iu | id) == '0, "R3", "idle bank active lines", $countones(iu | id), 0);
      chk(((du ^ dd) == 26'h3FFFFFF) && ((du & dd) == '0), "R4", "elements driven once",
          $countones(du ^ dd) - $countones(du & dd), 26);
      e = satv(pc);
      v = int'($signed(pc));
      chk(wsum(du) == 2 * e, (v != e) ? "R6" : "R5", "weighted sum x2", wsum(du), 2 * e);
      tr = 0;
      cp = 0;
      for (int i = 0; i < 16; i++) begin
        if (du[i] != du[(i + 1) % 16]) tr++;
        if (du[i]) cp++;
      end
      chk(tr <= 2, "R8", "coarse ring transitions", tr, 2);
      if (cp > 0 && cp < 16)
        for (int i = 0; i < 16; i++)
          if (du[i] && !du[(i + 15) % 16]) seen_start[i] = 1;
      for (int j = 0; j < 5; j++)
        if (du[16 + 2*j] != du[17 + 2*j]) seen_or[j][du[16 + 2*j]] = 1;
      if (qw && qs == ps && qc == pc)
        chk(du == q_du, "R9", "pattern changed inside window", $countones(du ^ q_du), 0);
    end
    qw = pw; qs = ps; qc = pc; q_du = du;
  endtask

  task automatic cyc(input logic w, input logic s, input logic [9:0] c);
    @(negedge clk);
    check_out();
    win = w; bank_sel = s; code = c;
    pw = w; ps = s; pc = c;
  endtask

  task automatic period(input logic s, input logic [9:0] c, input int len, input int gap);
    for (int i = 0; i < len; i++) cyc(1'b1, s, c);
    for (int i = 0; i < gap; i++) cyc(1'b0, 1'b0, '0);
  endtask

  initial begin
    int dir [18] = '{0, 1, -1, 31, 32, -32, -33, 255, 256, -256, 287, -287, 288, -288, 511, -512, 100, -77};
    int nstart;
    win = 1'b1; bank_sel = 1'b1; code = 10'd100;
    repeat (3) begin
      @(negedge clk);
      chk((hi_up | hi_dn | lo_up | lo_dn) == '0, "R1", "lines active in reset",
          $countones(hi_up | hi_dn | lo_up | lo_dn), 0);
    end
    win = 1'b0; bank_sel = 1'b0; code = '0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk((hi_up | hi_dn | lo_up | lo_dn) == '0, "R1", "lines active after reset",
        $countones(hi_up | hi_dn | lo_up | lo_dn), 0);

    for (int i = 0; i < 18; i++) period(i[0], 10'(dir[i]), 3, 1);

    for (int n = 0; n < 3000; n++) begin
      logic [9:0] c = 10'($urandom);
      logic s = 1'($urandom);
      int len = 1 + int'($urandom % 4);
      int gap = 1 + int'($urandom % 3);
      for (int i = 0; i < len; i++) begin
        if (($urandom % 4) == 0) c = 10'($urandom);
        cyc(1'b1, s, c);
      end
      for (int i = 0; i < gap; i++) cyc(1'b0, 1'b0, '0);
    end
    cyc(1'b0, 1'b0, '0);
    cyc(1'b0, 1'b0, '0);

    nstart = 0;
    for (int i = 0; i < 16; i++) if (seen_start[i]) nstart++;
    chk(nstart >= 8, "R8", "distinct coarse run starts", nstart, 8);
    for (int j = 0; j < 5; j++)
      chk(seen_or[j][0] && seen_or[j][1], "R7", "pair orientations seen",
          int'(seen_or[j][0]) + int'(seen_or[j][1]), 2);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog run did not finish actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule